// File: doc/BRIEF.md
# Per-Channel Window Limit Monitor

This block sits behind a multi-channel analog-to-digital converter and watches every conversion result as it arrives. Each result comes with a channel index and a 10-bit value on a one-cycle valid strobe. The block compares the value against that channel's programmable lower and upper limits. It keeps a running maximum and minimum for each channel, which software can clear. It records per-channel events for "result seen", "below lower limit" and "above upper limit", plus one global event for a badly programmed window, in sticky status bits.

A simple register port (write strobe, address, write data, combinational read data) gives access to the per-channel limit words, the event mask, the status word and the per-channel history words. A single interrupt line is the OR of every status bit whose mask bit is clear.

Results are handled by a two-state machine. `ST_IDLE` is the state with no result pending. A valid strobe moves it to `ST_EVAL` (transition *accept*). In `ST_EVAL` the captured result is compared and committed. It stays in `ST_EVAL` when another strobe arrives (transition *chain*), which gives one result per cycle. It returns to `ST_IDLE` when no strobe arrives (transition *drain*). With no strobe in `ST_IDLE` it stays there (transition *wait*).

Top module: `cwm_top`

## Requirements
- R1: After reset the mask word reads all ones (0x1FFF for 4 channels). The status word reads 0 and irq is 0. Every limit word reads lower 0 and upper 0x3FF (0x03FF0000). Every history word reads upper 0 and lower 0x3FF (0x000003FF).
- R2: Each accepted result sets status bit `ch` (finished event) at the second rising edge after the strobe is sampled. Strobes on consecutive cycles are all accepted.
- R3: A result strictly greater than its channel's upper limit sets status bit `2*NUM_CH+ch`. A result equal to the limit does not.
- R4: A result strictly less than its channel's lower limit sets status bit `NUM_CH+ch`. A result equal to the limit does not.
- R5: When the checked channel's lower limit is not below its upper limit, status bit `3*NUM_CH` (error) is set. With a valid window it is not set.
- R6: The history word at address 0x20+ch holds the largest result since the last clear in bits 31:16 and the smallest in bits 15:0. Any write to that address clears it to its reset value.
- R7: The status word at address 0x01 is sticky and write-one-to-clear. When a new event and a clear of the same bit meet in one cycle, the bit stays set.
- R8: The mask word sits at address 0x00, with the same bit layout as status. A mask bit of 1 keeps its status bit off irq, and a masked event is still recorded in status. irq is high when any status bit has its mask bit at 0.
- R9: The limit word at address 0x10+ch holds the upper limit in bits 25:16 and the lower limit in bits 9:0, and reads back as written. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | Conversion result strobe |
| res_ch | input | CH_W | Channel of the result |
| res_val | input | RES_W | Result value |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq | output | 1 | Combined unmasked event line |

## Verification
Some properties are checked by assertions on every cycle. A strobe always leads to an evaluation cycle. An idle cycle raises no event. A valid window never produces both limit events. A history maximum never shrinks without a clear, and a channel's history is untouched by results on other channels. Status bits stay set until cleared, a new event wins over a clear, and a fully masked status keeps irq low. Other behaviours need the bench's scenarios: the exact limit bits at and beside each threshold, the error on a degenerate window, the packed history after a mixed sequence and a back-to-back burst, the readback layout, and irq following mask changes.

// File: rtl/cwm_pkg.sv
package cwm_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EVAL = 1'b1
    } eval_state_t;

    localparam int ADDR_W = 6;
    localparam int LVL_HI_LSB = 16;
    localparam int HIST_HI_LSB = 16;

    localparam logic [ADDR_W-1:0] ADR_MASK   = 6'h00;
    localparam logic [ADDR_W-1:0] ADR_STATUS = 6'h01;
    localparam logic [ADDR_W-1:0] ADR_LEVEL  = 6'h10;
    localparam logic [ADDR_W-1:0] ADR_HIST   = 6'h20;

endpackage

// File: rtl/cwm_regs.sv
module cwm_regs
    import cwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int RES_W  = 10,
    parameter int EV_W   = 3 * NUM_CH + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [31:0]          reg_wdata,
    input  logic [EV_W-1:0]      status_q,
    input  logic [RES_W-1:0]     hist_hi [NUM_CH],
    input  logic [RES_W-1:0]     hist_lo [NUM_CH],
    output logic [EV_W-1:0]      mask_q,
    output logic [RES_W-1:0]     lvl_lo [NUM_CH],
    output logic [RES_W-1:0]     lvl_hi [NUM_CH],
    output logic [EV_W-1:0]      w1c,
    output logic [NUM_CH-1:0]    hist_clr,
    output logic [31:0]          reg_rdata
);

    localparam logic [RES_W-1:0] FULL_SCALE = '1;

    wire unused_wdata_bits = ^reg_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (reg_wr && reg_addr == ADR_MASK) begin
            mask_q <= reg_wdata[EV_W-1:0];
        end
    end

    assign w1c = (reg_wr && reg_addr == ADR_STATUS) ? reg_wdata[EV_W-1:0] : '0;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        logic lvl_sel;
        assign lvl_sel     = reg_wr && (reg_addr == ADR_LEVEL + 6'(g));
        assign hist_clr[g] = reg_wr && (reg_addr == ADR_HIST + 6'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lvl_lo[g] <= '0;
                lvl_hi[g] <= FULL_SCALE;
            end else if (lvl_sel) begin
                lvl_lo[g] <= reg_wdata[RES_W-1:0];
                lvl_hi[g] <= reg_wdata[LVL_HI_LSB +: RES_W];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADR_MASK) begin
            reg_rdata[EV_W-1:0] = mask_q;
        end
        if (reg_addr == ADR_STATUS) begin
            reg_rdata[EV_W-1:0] = status_q;
        end
        for (int c = 0; c < NUM_CH; c++) begin
            if (reg_addr == ADR_LEVEL + 6'(c)) begin
                reg_rdata[LVL_HI_LSB +: RES_W] = lvl_hi[c];
                reg_rdata[RES_W-1:0]           = lvl_lo[c];
            end
            if (reg_addr == ADR_HIST + 6'(c)) begin
                reg_rdata[HIST_HI_LSB +: RES_W] = hist_hi[c];
                reg_rdata[RES_W-1:0]            = hist_lo[c];
            end
        end
    end

    // R7: a status write only ever clears bits named in its data
    a_r7_w1c_source: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == ADR_STATUS) |-> (w1c == '0));

endmodule

// File: rtl/cwm_eval.sv
module cwm_eval
    import cwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int RES_W  = 10,
    parameter int EV_W   = 3 * NUM_CH + 1,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [CH_W-1:0]   res_ch,
    input  logic [RES_W-1:0]  res_val,
    input  logic [RES_W-1:0]  lvl_lo [NUM_CH],
    input  logic [RES_W-1:0]  lvl_hi [NUM_CH],
    output logic              fire,
    output logic [CH_W-1:0]   cap_ch,
    output logic [RES_W-1:0]  cap_val,
    output logic [EV_W-1:0]   ev_set
);

    eval_state_t state_q, state_d;
    logic [NUM_CH-1:0] fin_v, low_v, up_v;
    logic              err_v;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_ch  <= '0;
            cap_val <= '0;
        end else if (res_valid) begin
            cap_ch  <= res_ch;
            cap_val <= res_val;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = res_valid ? ST_EVAL : ST_IDLE;
            ST_EVAL: state_d = res_valid ? ST_EVAL : ST_IDLE;
        endcase
    end

    always_comb begin
        fire  = 1'b0;
        fin_v = '0;
        low_v = '0;
        up_v  = '0;
        err_v = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_EVAL: begin
                fire          = 1'b1;
                fin_v[cap_ch] = 1'b1;
                if (cap_val > lvl_hi[cap_ch]) up_v[cap_ch]  = 1'b1;
                if (cap_val < lvl_lo[cap_ch]) low_v[cap_ch] = 1'b1;
                if (lvl_lo[cap_ch] >= lvl_hi[cap_ch]) err_v = 1'b1;
            end
        endcase
    end

    assign ev_set = {err_v, up_v, low_v, fin_v};

    // R2: every sampled strobe is evaluated in the next cycle
    a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> fire);

    // R2: no event appears without a pending result
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |-> (ev_set == '0));

    // R3/R4: a well-formed window never yields both limit events at once
    a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !ev_set[EV_W-1]) |-> !((|up_v) && (|low_v)));

endmodule

// File: rtl/cwm_hist.sv
module cwm_hist #(
    parameter int NUM_CH = 4,
    parameter int RES_W  = 10,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [CH_W-1:0]   cap_ch,
    input  logic [RES_W-1:0]  cap_val,
    input  logic [NUM_CH-1:0] hist_clr,
    output logic [RES_W-1:0]  hist_hi [NUM_CH],
    output logic [RES_W-1:0]  hist_lo [NUM_CH]
);

    localparam logic [RES_W-1:0] FULL_SCALE = '1;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        logic hit;
        assign hit = fire && (cap_ch == CH_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hist_hi[g] <= '0;
                hist_lo[g] <= FULL_SCALE;
            end else if (hist_clr[g]) begin
                hist_hi[g] <= '0;
                hist_lo[g] <= FULL_SCALE;
            end else if (hit) begin
                if (cap_val > hist_hi[g]) hist_hi[g] <= cap_val;
                if (cap_val < hist_lo[g]) hist_lo[g] <= cap_val;
            end
        end

        // R6: the maximum only grows until a clear
        a_r6_hi_monotone: assert property (@(posedge clk) disable iff (!rst_n)
            !hist_clr[g] |=> (hist_hi[g] >= $past(hist_hi[g])));

        // R6: the minimum only shrinks until a clear
        a_r6_lo_monotone: assert property (@(posedge clk) disable iff (!rst_n)
            !hist_clr[g] |=> (hist_lo[g] <= $past(hist_lo[g])));

        // R6: results on other channels leave this history alone
        a_r6_isolated: assert property (@(posedge clk) disable iff (!rst_n)
            (!hit && !hist_clr[g]) |=> ($stable(hist_hi[g]) && $stable(hist_lo[g])));
    end

endmodule

// File: rtl/cwm_status.sv
module cwm_status #(
    parameter int EV_W = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [EV_W-1:0] ev_set,
    input  logic [EV_W-1:0] w1c,
    input  logic [EV_W-1:0] mask_q,
    output logic [EV_W-1:0] status_q,
    output logic            irq
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~w1c) | ev_set;
        end
    end

    assign irq = |(status_q & ~mask_q);

    // R7: set bits survive a cycle without a clear
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c == '0) |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R7: a fresh event wins over a same-cycle clear
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_set != '0) |=> ((status_q & $past(ev_set)) == $past(ev_set)));

    // R8: a fully masked status never drives the line
    a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_q) |-> !irq);

endmodule

// File: rtl/cwm_top.sv
module cwm_top
    import cwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int RES_W  = 10,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [CH_W-1:0]   res_ch,
    input  logic [RES_W-1:0]  res_val,
    input  logic              reg_wr,
    input  logic [5:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);

    localparam int EV_W = 3 * NUM_CH + 1;

    logic [EV_W-1:0]   mask_q;
    logic [EV_W-1:0]   status_q;
    logic [EV_W-1:0]   w1c;
    logic [EV_W-1:0]   ev_set;
    logic [NUM_CH-1:0] hist_clr;
    logic [RES_W-1:0]  lvl_lo  [NUM_CH];
    logic [RES_W-1:0]  lvl_hi  [NUM_CH];
    logic [RES_W-1:0]  hist_hi [NUM_CH];
    logic [RES_W-1:0]  hist_lo [NUM_CH];
    logic              fire;
    logic [CH_W-1:0]   cap_ch;
    logic [RES_W-1:0]  cap_val;

    cwm_regs #(.NUM_CH(NUM_CH), .RES_W(RES_W), .EV_W(EV_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .status_q  (status_q),
        .hist_hi   (hist_hi),
        .hist_lo   (hist_lo),
        .mask_q    (mask_q),
        .lvl_lo    (lvl_lo),
        .lvl_hi    (lvl_hi),
        .w1c       (w1c),
        .hist_clr  (hist_clr),
        .reg_rdata (reg_rdata)
    );

    cwm_eval #(.NUM_CH(NUM_CH), .RES_W(RES_W), .EV_W(EV_W)) u_eval (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_valid (res_valid),
        .res_ch    (res_ch),
        .res_val   (res_val),
        .lvl_lo    (lvl_lo),
        .lvl_hi    (lvl_hi),
        .fire      (fire),
        .cap_ch    (cap_ch),
        .cap_val   (cap_val),
        .ev_set    (ev_set)
    );

    cwm_hist #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .cap_ch   (cap_ch),
        .cap_val  (cap_val),
        .hist_clr (hist_clr),
        .hist_hi  (hist_hi),
        .hist_lo  (hist_lo)
    );

    cwm_status #(.EV_W(EV_W)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_set   (ev_set),
        .w1c      (w1c),
        .mask_q   (mask_q),
        .status_q (status_q),
        .irq      (irq)
    );

    // R8: the line is never high while status is empty
    a_r8_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q == '0) |-> !irq);

endmodule

// File: tb/sim_cwm_top.sv
module sim_cwm_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [1:0]  res_ch = '0;
    logic [9:0]  res_val = '0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    always #10 clk = ~clk;

    cwm_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_valid (res_valid),
        .res_ch    (res_ch),
        .res_val   (res_val),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    typedef struct {
        bit          is_irq;
        logic [5:0]  addr;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // monitor: compares the oldest expected item, then retires it
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb.size() > 0) begin
                logic [31:0] act;
                if (!sb[0].is_irq) reg_addr = sb[0].addr;
                #2;
                act = sb[0].is_irq ? {31'b0, irq} : reg_rdata;
                n_cmp++;
                if (act !== sb[0].exp) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", sb[0].tag, act, sb[0].exp);
                end
                void'(sb.pop_front());
            end
        end
    end

    task automatic expect_reg(input logic [5:0] a, input logic [31:0] e, input string tag);
        sb_item_t it;
        it.is_irq = 1'b0; it.addr = a; it.exp = e; it.tag = tag;
        #2;
        sb.push_back(it);
        wait (sb.size() == 0);
    endtask

    task automatic expect_irq(input logic e, input string tag);
        sb_item_t it;
        it.is_irq = 1'b1; it.addr = '0; it.exp = {31'b0, e}; it.tag = tag;
        #2;
        sb.push_back(it);
        wait (sb.size() == 0);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic result(input logic [1:0] ch, input logic [9:0] v);
        @(negedge clk);
        res_valid = 1'b1; res_ch = ch; res_val = v;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        expect_reg(6'h00, 32'h0000_1FFF, "R1 mask reset");
        expect_reg(6'h01, 32'h0, "R1 status reset");
        expect_reg(6'h10, 32'h03FF_0000, "R1 level reset");
        expect_reg(6'h22, 32'h0000_03FF, "R1 history reset");
        expect_irq(1'b0, "R1 irq reset");

        // R9 level layout and unmapped read
        wr(6'h10, (32'd500 << 16) | 32'd100);
        expect_reg(6'h10, 32'h01F4_0064, "R9 level readback");
        expect_reg(6'h05, 32'h0, "R9 unmapped read");

        // R2 finished event, R5 no error on valid window
        result(2'd0, 10'd300);
        expect_reg(6'h01, 32'h001, "R2 finished only");
        wr(6'h01, 32'h001);
        expect_reg(6'h01, 32'h0, "R7 w1c clears");

        // R3 upper limit, strict
        result(2'd0, 10'd501);
        expect_reg(6'h01, 32'h101, "R3 above upper");
        wr(6'h01, 32'h1FFF);
        result(2'd0, 10'd500);
        expect_reg(6'h01, 32'h001, "R3 equal upper");
        wr(6'h01, 32'h1FFF);

        // R4 lower limit, strict
        result(2'd0, 10'd99);
        expect_reg(6'h01, 32'h011, "R4 below lower");
        wr(6'h01, 32'h1FFF);
        result(2'd0, 10'd100);
        expect_reg(6'h01, 32'h001, "R4 equal lower");
        wr(6'h01, 32'h1FFF);

        // R8 masking
        result(2'd0, 10'd99);
        expect_reg(6'h01, 32'h011, "R8 masked still recorded");
        expect_irq(1'b0, "R8 all masked");
        wr(6'h00, 32'h1FEF);
        expect_irq(1'b1, "R8 unmasked lower ch0");
        wr(6'h01, 32'h010);
        expect_reg(6'h01, 32'h001, "R7 partial clear");
        expect_irq(1'b0, "R8 irq drops after clear");
        wr(6'h01, 32'h1FFF);

        // R5 degenerate window raises error
        wr(6'h11, (32'd200 << 16) | 32'd200);
        result(2'd1, 10'd50);
        expect_reg(6'h01, 32'h1022, "R5 error on bad window");
        expect_reg(6'h21, 32'h0032_0032, "R6 history ch1");
        wr(6'h01, 32'h1FFF);

        // R6 history after mixed sequence, then clear
        expect_reg(6'h20, 32'h01F5_0063, "R6 history ch0");
        wr(6'h20, 32'h0);
        expect_reg(6'h20, 32'h0000_03FF, "R6 history clear");

        // R2 back-to-back burst on ch3
        @(negedge clk);
        res_valid = 1'b1; res_ch = 2'd3; res_val = 10'd7;
        @(negedge clk);
        res_val = 10'd1000;
        @(negedge clk);
        res_val = 10'd512;
        @(negedge clk);
        res_valid = 1'b0;
        expect_reg(6'h23, 32'h03E8_0007, "R2 burst history ch3");
        expect_reg(6'h01, 32'h008, "R2 burst finished ch3");
        wr(6'h01, 32'h1FFF);
        expect_reg(6'h01, 32'h0, "R7 cleared before race");

        // R7 new event wins over same-cycle clear
        @(negedge clk);
        res_valid = 1'b1; res_ch = 2'd3; res_val = 10'd20;
        @(negedge clk);
        res_valid = 1'b0;
        reg_addr = 6'h01; reg_wdata = 32'h008; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        expect_reg(6'h01, 32'h008, "R7 set wins over clear");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule